// File: doc/BRIEF.md
# Serial Clock Generator with Stretch Synchronization

This block is the master-side clock source for a two-wire serial unit. It produces an internal serial clock whose low and high phases come from two programmable cycle counts, and it drives the open-drain clock pin low during every low phase. During a high phase it releases the pin.

The pin level is read back through a two-flop synchronizer and a consecutive-sample noise filter. The filter samples on a tick from a programmable divider. When the synchronization enable is set, counting of the high phase does not begin until the filtered pin has been seen high. A slave can therefore stretch the clock by holding the line low. Because the counter waits for the pin, every high phase also grows by the output, filter and recognition delay, even when no device holds the line. When synchronization is set, the clock handed to the data path is the internal clock ANDed with the filtered pin. When it is clear, the data path clock is the internal clock alone.

A one-cycle request pulse asks for the timing of a start, restart or stop condition. The block finishes a released (high) phase and then raises a one-cycle completion pulse. A stretch that is still present before the high count starts delays the completion pulse. A stretch that begins after the high count has started does not delay it.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset the pin is released (`scl_pull_low`=0), `cond_done` is 0 and `shift_clk` is 1.
- R2: With `run_en`=1 each low phase holds `scl_pull_low`=1 for exactly max(`low_count`,1) cycles, whatever the pin level is during that phase.
- R3: With `sync_en`=0 each released phase lasts exactly max(`high_count`,1) cycles, even while another device holds the line low.
- R4: With `sync_en`=1 and nothing holding the line, a released phase lasts T cycles, where max(H,1) < T <= H + 4 + (D+1)*(N+1). Here H=`high_count`, D=`filt_div` and N=`FILT_N`.
- R5: With `sync_en`=1 and a slave holding the line past the release, high counting waits. The time the line is then seen high before the next low phase, L_hi, meets H < L_hi <= H + 4 + (D+1)*(N+1).
- R6: With `sync_en`=0, `shift_clk` is always the inverse of `scl_pull_low`.
- R7: With `sync_en`=1, `shift_clk` is 0 while the filtered line is low, even when the pin is released. It is 1 when the line is released and has settled high.
- R8: With `sync_en`=0 and the block idle, a `cond_req` pulse sampled at one edge gives `cond_done`=1 for one cycle, exactly max(H,1) edges later. The pin is not pulled low meanwhile.
- R9: With `sync_en`=1, idle and a high line, `cond_done` follows `cond_req` after exactly max(H,1)+1 edges. If the line is held low when the request arrives, the wait grows by at least the number of cycles it stays low.
- R10: With `sync_en`=1, a line stretch that starts after high counting has begun does not change the request-to-`cond_done` time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run the free clock (low/high phases) |
| sync_en | input | 1 | Wait for the pin before counting the high phase |
| low_count | input | CNT_W | Low phase length in cycles (0 treated as 1) |
| high_count | input | CNT_W | High phase length in cycles (0 treated as 1) |
| filt_div | input | DIV_W | Filter sample tick every filt_div+1 cycles |
| cond_req | input | 1 | One-cycle request for start/restart/stop timing |
| scl_pin_i | input | 1 | Level read back from the clock pin |
| scl_pull_low | output | 1 | 1 = drive pin to 0, 0 = release to high impedance |
| shift_clk | output | 1 | Qualified clock for the data path |
| cond_done | output | 1 | One-cycle completion pulse for a condition request |

## Verification
The hardest case to reach is a stretch that begins only after high counting has started. From the ports alone, the bench cannot see when counting starts. The bench issues the request from idle with a settled high line, so it knows from R9 the exact edge at which the released phase begins. It then pulls the line low a few cycles after that edge and holds it longer than the filter delay. The completion pulse must still arrive on the same edge as in the unstretched run. The opposite case holds the line low before the request and releases it at a known count, so the growth in the wait can be bounded.

// File: rtl/scl_gen_pkg.sv
// Package: shared types for the serial clock generator.
// Assumes: imported by every module of the block.
package scl_gen_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,  // released, not counting
        PH_LOW     = 2'd1,  // pin driven low, counting low period
        PH_WAIT_HI = 2'd2,  // released, waiting for filtered pin high
        PH_HIGH    = 2'd3   // released, counting high period
    } phase_t;

endpackage

// File: rtl/scl_tick_div.sv
// Module: scl_tick_div
// Produces a one-cycle sample tick every (div+1) clock cycles for the
// pin noise filter.
// Assumes: div is quasi-static; a change takes effect within one period.
module scl_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div);

    // Free-running divider counter, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_pin_filter.sv
// Module: scl_pin_filter
// Two-flop synchronizer followed by a consecutive-sample filter: the
// filtered level changes only after FILT_N equal samples taken on tick.
// Assumes: idle bus level is high; FILT_N >= 2.
module scl_pin_filter #(
    parameter int FILT_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_i,
    output logic level_o
);

    logic              meta_q;
    logic              sync_q;
    logic [FILT_N-1:0] hist_q;
    logic              level_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Shift in samples on tick and update level once all agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '1;
            level_q <= 1'b1;
        end else if (tick) begin
            hist_q <= {hist_q[FILT_N-2:0], sync_q};
            if (&hist_q) begin
                level_q <= 1'b1;
            end else if (~|hist_q) begin
                level_q <= 1'b0;
            end
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/scl_phase_fsm.sv
// Module: scl_phase_fsm
// Sequences low, wait and high phases, counts their lengths and times
// condition requests. A request is finished at the end of a high phase.
// Assumes: counts are stable while a phase runs; a count of 0 means 1.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sync_en,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             pin_high,
    input  logic             cond_req,
    output logic             drive_low,
    output logic             int_clk,
    output logic             cond_done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             done_q;
    logic             done_d;
    logic             start_cond;
    logic [CNT_W-1:0] lim_low;
    logic [CNT_W-1:0] lim_high;
    phase_t           rise_phase;

    assign start_cond = cond_req | pend_q;
    assign lim_low    = (low_count  == '0) ? CNT_ONE : low_count;
    assign lim_high   = (high_count == '0) ? CNT_ONE : high_count;
    assign rise_phase = sync_en ? PH_WAIT_HI : PH_HIGH;

    // Next phase and completion decision.
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start_cond) begin
                    state_d = rise_phase;
                end else if (run_en) begin
                    state_d = PH_LOW;
                end
            end
            PH_LOW: begin
                if (cnt_q >= lim_low) begin
                    state_d = rise_phase;
                end
            end
            PH_WAIT_HI: begin
                if (pin_high || !sync_en) begin
                    state_d = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (cnt_q >= lim_high) begin
                    if (start_cond) begin
                        done_d  = 1'b1;
                        state_d = PH_IDLE;
                    end else if (run_en) begin
                        state_d = PH_LOW;
                    end else begin
                        state_d = PH_IDLE;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // Phase length counter: restarts at 1 on each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pending request flag, held until its completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | cond_req) & ~done_d;
        end
    end

    assign drive_low = (state_q == PH_LOW);
    assign int_clk   = ~drive_low;
    assign cond_done = done_q;

endmodule

// File: rtl/scl_clock_gen.sv
// Module: scl_clock_gen (top)
// Master serial clock generator with optional stretch synchronization.
// Combines the sample divider, pin filter and phase sequencer, and forms
// the qualified data path clock.
// Assumes: scl_pin_i reads the wired line; an external open-drain pad
// drives 0 when scl_pull_low is 1.
module scl_clock_gen #(
    parameter int CNT_W  = 8,
    parameter int DIV_W  = 8,
    parameter int FILT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             sync_en,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic [DIV_W-1:0] filt_div,
    input  logic             cond_req,
    input  logic             scl_pin_i,
    output logic             scl_pull_low,
    output logic             shift_clk,
    output logic             cond_done
);

    logic sample_tick;
    logic pin_level;
    logic int_clk;

    scl_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (filt_div),
        .tick  (sample_tick)
    );

    scl_pin_filter #(.FILT_N(FILT_N)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .pin_i   (scl_pin_i),
        .level_o (pin_level)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .sync_en    (sync_en),
        .low_count  (low_count),
        .high_count (high_count),
        .pin_high   (pin_level),
        .cond_req   (cond_req),
        .drive_low  (scl_pull_low),
        .int_clk    (int_clk),
        .cond_done  (cond_done)
    );

    // Data path clock: AND with the line when synchronizing.
    always_comb begin
        shift_clk = sync_en ? (int_clk & pin_level) : int_clk;
    end

endmodule

// File: rtl/scl_clock_gen_chk.sv
// Module: scl_clock_gen_chk
// Property checker bound to scl_clock_gen; watches ports only.
// Assumes: counts stay stable while the clock runs.
module scl_clock_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_en,
    input logic [CNT_W-1:0] low_count,
    input logic             scl_pull_low,
    input logic             shift_clk,
    input logic             cond_done
);

    logic [CNT_W:0] low_run_q;
    logic [CNT_W:0] low_lim;

    assign low_lim = (low_count == '0) ? (CNT_W+1)'(1) : {1'b0, low_count};

    // Length of the current pull-low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!scl_pull_low) begin
            low_run_q <= '0;
        end else if (low_run_q != '1) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_done |=> !cond_done);

    assert_shift_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> (shift_clk == !scl_pull_low));

    assert_shift_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_low |-> !shift_clk);

    assert_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull_low |-> (low_run_q < low_lim));

    assert_no_pull_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cond_done) |-> !scl_pull_low);

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_en      (sync_en),
    .low_count    (low_count),
    .scl_pull_low (scl_pull_low),
    .shift_clk    (shift_clk),
    .cond_done    (cond_done)
);

// File: tb/sim_scl_clock_gen.sv
`timescale 1ns/1ps
module sim_scl_clock_gen;

    localparam int CNT_W  = 8;
    localparam int DIV_W  = 8;
    localparam int FILT_N = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic             sync_en = 1'b0;
    logic [CNT_W-1:0] low_count = 8'd6;
    logic [CNT_W-1:0] high_count = 8'd5;
    logic [DIV_W-1:0] filt_div = 8'd1;
    logic             cond_req = 1'b0;
    logic             slave_hold = 1'b0;
    logic             scl_line;
    logic             scl_pull_low;
    logic             shift_clk;
    logic             cond_done;

    int n_checks = 0;
    int n_fail = 0;

    // Wired line: low when either side pulls it low.
    assign scl_line = ~(scl_pull_low | slave_hold);

    always #2.5 clk = ~clk;

    scl_clock_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W), .FILT_N(FILT_N)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .sync_en      (sync_en),
        .low_count    (low_count),
        .high_count   (high_count),
        .filt_div     (filt_div),
        .cond_req     (cond_req),
        .scl_pin_i    (scl_line),
        .scl_pull_low (scl_pull_low),
        .shift_clk    (shift_clk),
        .cond_done    (cond_done)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    function automatic int lim(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int sync_bound(input int h);
        return lim(h) + 4 + (int'(filt_div) + 1) * (FILT_N + 1);
    endfunction

    // Wait at negedges for the start of a pull-low run.
    task automatic wait_low_start();
        while (scl_pull_low) @(negedge clk);
        while (!scl_pull_low) @(negedge clk);
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (scl_pull_low) begin n++; @(negedge clk); end
    endtask

    task automatic count_released(output int n);
        n = 0;
        while (!scl_pull_low) begin n++; @(negedge clk); end
    endtask

    task automatic go_idle();
        run_en = 1'b0;
        slave_hold = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    // Reset values at the ports.
    task automatic t_reset();
        @(negedge clk);
        check("R1 pull_low", int'(scl_pull_low), 0);
        check("R1 cond_done", int'(cond_done), 0);
        check("R1 shift_clk", int'(shift_clk), 1);
    endtask

    // Free running, sync off: exact phase lengths, pin ignored.
    task automatic t_plain_phases();
        int n;
        sync_en = 1'b0; low_count = 8'd6; high_count = 8'd5;
        run_en = 1'b1;
        wait_low_start();
        count_low(n);
        check("R2 low len", n, 6);
        count_released(n);
        check("R3 high len", n, 5);
        // Slave holds the line over a whole period: lengths unchanged.
        slave_hold = 1'b1;
        count_low(n);
        check("R2 low len, line held", n, 6);
        check("R6 shift vs pull", int'(shift_clk), int'(!scl_pull_low));
        count_released(n);
        check("R3 high len, line held", n, 5);
        slave_hold = 1'b0;
        go_idle();
        low_count = 8'd0; high_count = 8'd0;
        run_en = 1'b1;
        wait_low_start();
        count_low(n);
        check("R2 zero low count", n, 1);
        count_released(n);
        check("R3 zero high count", n, 1);
        go_idle();
    endtask

    // Sync on without stretch: high grows by recognition delay only.
    task automatic t_sync_nostretch();
        int n;
        sync_en = 1'b1; low_count = 8'd6; high_count = 8'd5;
        run_en = 1'b1;
        wait_low_start();
        count_low(n);
        check("R2 low len, sync", n, 6);
        count_released(n);
        check_range("R4 released len", n, 6, sync_bound(5));
        count_low(n);
        count_released(n);
        check_range("R4 released len again", n, 6, sync_bound(5));
        go_idle();
    endtask

    // Sync on with slave stretch past release.
    task automatic t_sync_stretch();
        int n;
        sync_en = 1'b1; low_count = 8'd6; high_count = 8'd5;
        run_en = 1'b1;
        wait_low_start();
        slave_hold = 1'b1;
        repeat (6 + 20) @(negedge clk);
        check("R5 still released during stretch", int'(scl_pull_low), 0);
        check("R7 shift low while line held", int'(shift_clk), 0);
        slave_hold = 1'b0;
        count_released(n);
        check_range("R5 line-high len", n, 6, sync_bound(5));
        wait_low_start();
        repeat (6 + 2) @(negedge clk);
        while (!scl_line || !shift_clk) begin
            if (scl_pull_low) break;
            @(negedge clk);
        end
        check("R7 shift high once settled", int'(shift_clk), 1);
        go_idle();
    endtask

    // Issue one request from idle; returns edges to done.
    task automatic do_request(input int h0, input int h1, output int n,
                              output int pulled);
        pulled = 0;
        @(negedge clk);
        cond_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cond_req = 1'b0;
        n = 0;
        while (n < 1000) begin
            @(posedge clk);
            n++;
            if (n == h0) slave_hold = 1'b1;
            if (n == h1) slave_hold = 1'b0;
            @(negedge clk);
            if (scl_pull_low) pulled++;
            if (cond_done) break;
        end
    endtask

    task automatic t_cond_plain();
        int n, p;
        sync_en = 1'b0; high_count = 8'd7;
        go_idle();
        do_request(-1, -1, n, p);
        check("R8 request to done", n, 7);
        check("R8 no pull during condition", p, 0);
        @(negedge clk);
        check("R8 done one cycle", int'(cond_done), 0);
    endtask

    task automatic t_cond_sync();
        int n, p;
        sync_en = 1'b1; high_count = 8'd20;
        go_idle();
        do_request(-1, -1, n, p);
        check("R9 request to done, sync", n, 21);
        // Line already held low when the request arrives.
        go_idle();
        slave_hold = 1'b1;
        repeat (30) @(negedge clk);
        do_request(-1, 15, n, p);
        check_range("R9 stretched before rise", n, 21 + 15, 21 + 15 + sync_bound(0));
        // Stretch starting after high counting began.
        go_idle();
        do_request(3, 13, n, p);
        check("R10 stretch after rise", n, 21);
        check("R10 no pull during condition", p, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_phases();
        t_sync_nostretch();
        t_sync_stretch();
        t_cond_plain();
        t_cond_sync();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule